// File: doc/BRIEF.md
# Ring dot-product matrix multiplier

The block multiplies two integer matrices, C = A x B, on a ring of identical processing elements. A is N rows by P, B is P by N, and C is N by N, where N is the number of elements in the ring. Element i keeps row i of A and builds row i of C. Each element starts out holding column i of B. It streams that column against its A row through a pipelined signed multiply-accumulate unit. While it does so, it passes the same column, one word per cycle, to the element below it in the ring.

After P issue cycles every element holds the column that its upper neighbour held before, so the next dot product begins at once. After N such steps every element has met every column. Once the pipeline drains, the block raises `done`. Each element stores its C row starting from the diagonal entry and wrapping around, so all elements fill their rows with the same slot sequence. The read port undoes that rotation.

A caller first writes A and B one word per cycle through the load port. It then pulses `start`, waits for `done`, and reads any C entry through the combinational read port.

Top module: `ring_matmul`

## Requirements
- R1: While and after synchronous active-low reset, `done` is low and every C entry read through the port is 0.
- R2: When `done` is high, entry C[r][c] equals the sum over k of A[r][k]*B[k][c]. Operands are two's-complement signed and the sum is sign-extended to the AW-bit result.
- R3: `rd_data` combinationally returns C[`rd_row`][`rd_col`], and it holds steady while `done` stays high and the read address is unchanged.
- R4: `done` goes high exactly N*P+LAT clock edges after the edge that accepts `start`, where LAT is the multiply-accumulate pipeline depth.
- R5: Once high, `done` stays high until a new `start` is accepted. That `start` drives `done` low on the next edge.
- R6: A `start` that arrives while a computation is in progress is ignored and does not change when `done` rises.
- R7: Load writes that arrive while a computation is in progress are ignored.
- R8: A computation leaves A and B as they were loaded, so a second `start` without reloading gives the same C.
- R9: Load encoding: with `ld_is_b`=0 the write stores A[`ld_idx`][`ld_k`]. With `ld_is_b`=1 it stores B[`ld_k`][`ld_idx`], so `ld_idx` is the column.
- R10: No C entry changes while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Write one operand word this cycle |
| ld_is_b | input | 1 | 0 selects A, 1 selects B |
| ld_idx | input | IW | Row of A or column of B |
| ld_k | input | KW | Position along the dot-product length |
| ld_data | input | DW | Signed operand word |
| start | input | 1 | Begin a multiplication |
| done | output | 1 | C is complete |
| rd_row | input | IW | Row of C to read |
| rd_col | input | IW | Column of C to read |
| rd_data | output | AW | Signed C entry |

## Verification
The bench follows `done` every cycle against a countdown model. An off-by-one in the drain count or in the rotation count would therefore show up as `done` rising a cycle early or late. A design that reacts to a mid-run `start` would be caught the same way, because it would move that edge. The bench compares every C entry with a triple-loop product on random, extreme-negative and identity matrices. A wrong ring direction or a wrong diagonal slot mapping would leave entries in the wrong columns. A signedness error would break the -128 case. It also injects a load mid-run and repeats a run without reloading. A design that accepts late writes, or that leaves the operands rotated after a run, would then produce a different C.

// File: rtl/ring_matmul_pkg.sv
// Shared types and helpers for the ring matrix multiplier.
// Assumes indices passed to ring_slot are below n.
package ring_matmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } rm_state_e;

    // Slot that holds column col of row row in diagonal-first storage.
    function automatic int unsigned ring_slot(int unsigned col, int unsigned row, int unsigned n);
        return (col >= row) ? (col - row) : (col + n - row);
    endfunction

endpackage

// File: rtl/ring_matmul_mac.sv
// Pipelined signed multiply-accumulate unit.
// Accepts one operand pair per cycle. The product passes through LAT
// registers and is then added into an accumulator. On the last term of a
// dot product it emits a write of the finished sum to the given slot.
// Assumes LAT >= 2 and AW >= 2*DW, and that the terms arrive in order.
module ring_matmul_mac #(
    parameter int DW  = 8,
    parameter int AW  = 20,
    parameter int LAT = 9,
    parameter int IW  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic [IW-1:0]        in_slot,
    input  logic signed [DW-1:0] in_a,
    input  logic signed [DW-1:0] in_b,
    output logic                 wr_en,
    output logic [IW-1:0]        wr_slot,
    output logic signed [AW-1:0] wr_val
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod_q  [LAT];
    logic                 vld_q   [LAT];
    logic                 first_q [LAT];
    logic                 last_q  [LAT];
    logic [IW-1:0]        slot_q  [LAT];
    logic signed [AW-1:0] acc_q;
    logic signed [PW-1:0] mul;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] acc_next;

    assign mul      = in_a * in_b;
    assign prod_ext = AW'(prod_q[LAT-1]);
    assign acc_next = first_q[LAT-1] ? prod_ext : acc_q + prod_ext;

    // Product pipeline: stage 0 captures the product, later stages delay it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) begin
                prod_q[s]  <= '0;
                vld_q[s]   <= 1'b0;
                first_q[s] <= 1'b0;
                last_q[s]  <= 1'b0;
                slot_q[s]  <= '0;
            end
        end else begin
            prod_q[0]  <= mul;
            vld_q[0]   <= in_vld;
            first_q[0] <= in_first;
            last_q[0]  <= in_last;
            slot_q[0]  <= in_slot;
            for (int s = 1; s < LAT; s++) begin
                prod_q[s]  <= prod_q[s-1];
                vld_q[s]   <= vld_q[s-1];
                first_q[s] <= first_q[s-1];
                last_q[s]  <= last_q[s-1];
                slot_q[s]  <= slot_q[s-1];
            end
        end
    end

    // Accumulator: restarts on the first term of each dot product.
    always_ff @(posedge clk) begin
        if (!rst_n)                acc_q <= '0;
        else if (vld_q[LAT-1])     acc_q <= acc_next;
    end

    assign wr_en   = vld_q[LAT-1] && last_q[LAT-1];
    assign wr_slot = slot_q[LAT-1];
    assign wr_val  = acc_next;

endmodule

// File: rtl/ring_matmul_pe.sv
// One ring element: holds one A row, the B column currently passing
// through, a multiply-accumulate unit and its C row in diagonal-first order.
// On each issue cycle the A row rotates by one word, so it returns to its
// loaded order after a multiple of P issues. The column shifts by one word,
// taking the neighbour's head word at its tail.
// Assumes the loads and the issue are never active together; the top gates them.
module ring_matmul_pe #(
    parameter int N   = 4,
    parameter int P   = 3,
    parameter int DW  = 8,
    parameter int AW  = 20,
    parameter int LAT = 9,
    parameter int IW  = 2,
    parameter int KW  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_a_we,
    input  logic                     ld_b_we,
    input  logic [KW-1:0]            ld_k,
    input  logic signed [DW-1:0]     ld_data,
    input  logic                     issue,
    input  logic                     first,
    input  logic                     last,
    input  logic [IW-1:0]            slot,
    input  logic signed [DW-1:0]     b_in,
    output logic signed [DW-1:0]     b_out,
    output logic                     wr_en_o,
    output logic [N-1:0][AW-1:0]     c_row
);
    logic signed [DW-1:0] a_sr [P];
    logic signed [DW-1:0] b_sr [P];
    logic                 wr_en;
    logic [IW-1:0]        wr_slot;
    logic signed [AW-1:0] wr_val;
    logic                 k_ok;

    assign k_ok  = int'(ld_k) < P;
    assign b_out = b_sr[0];

    // Operand storage: rotate A, shift B along the ring, or take a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < P; j++) begin
                a_sr[j] <= '0;
                b_sr[j] <= '0;
            end
        end else if (issue) begin
            for (int j = 0; j < P - 1; j++) begin
                a_sr[j] <= a_sr[j+1];
                b_sr[j] <= b_sr[j+1];
            end
            a_sr[P-1] <= a_sr[0];
            b_sr[P-1] <= b_in;
        end else begin
            if (ld_a_we && k_ok) a_sr[ld_k] <= ld_data;
            if (ld_b_we && k_ok) b_sr[ld_k] <= ld_data;
        end
    end

    ring_matmul_mac #(.DW(DW), .AW(AW), .LAT(LAT), .IW(IW)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (issue),
        .in_first (first),
        .in_last  (last),
        .in_slot  (slot),
        .in_a     (a_sr[0]),
        .in_b     (b_sr[0]),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_val   (wr_val)
    );

    // Result row: slot s holds the column this element met at step s.
    always_ff @(posedge clk) begin
        if (!rst_n)      c_row <= '0;
        else if (wr_en)  c_row[wr_slot] <= wr_val;
    end

    assign wr_en_o = wr_en;

endmodule

// File: rtl/ring_matmul_ctrl.sv
// Lockstep sequencer shared by all ring elements.
// It counts P issue cycles per rotation step and N steps per run. It then
// waits LAT cycles for the pipelines to drain and holds done until the
// next start. A start is accepted only in the idle or done state.
// Assumes N >= 2, P >= 2 and LAT >= 2.
module ring_matmul_ctrl
    import ring_matmul_pkg::*;
#(
    parameter int N   = 4,
    parameter int P   = 3,
    parameter int LAT = 9,
    parameter int IW  = 2,
    parameter int KW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          issue,
    output logic          first,
    output logic          last,
    output logic [IW-1:0] slot,
    output logic          busy,
    output logic          done
);
    localparam int DCW = $clog2(LAT);

    rm_state_e      state;
    logic [KW-1:0]  kcnt;
    logic [IW-1:0]  scnt;
    logic [DCW-1:0] dcnt;

    // State and counters: advance issue position, rotation step and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            kcnt  <= '0;
            scnt  <= '0;
            dcnt  <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state <= ST_RUN;
                        kcnt  <= '0;
                        scnt  <= '0;
                    end
                end
                ST_RUN: begin
                    if (kcnt == KW'(P - 1)) begin
                        kcnt <= '0;
                        if (scnt == IW'(N - 1)) begin
                            state <= ST_DRAIN;
                            dcnt  <= '0;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end else begin
                        kcnt <= kcnt + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (dcnt == DCW'(LAT - 1)) state <= ST_DONE;
                    else                       dcnt  <= dcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign issue = (state == ST_RUN);
    assign first = (kcnt == '0);
    assign last  = (kcnt == KW'(P - 1));
    assign slot  = scnt;
    assign busy  = (state == ST_RUN) || (state == ST_DRAIN);
    assign done  = (state == ST_DONE);

endmodule

// File: rtl/ring_matmul.sv
// Top of the ring matrix multiplier: the load port, the sequencer, a
// generated ring of N elements, and the read port that maps (row, column)
// onto the diagonal-first slot of the row.
// Assumes N >= 2 and P >= 2; out-of-range loads are dropped and
// out-of-range reads return 0.
module ring_matmul
    import ring_matmul_pkg::*;
#(
    parameter int N   = 4,
    parameter int P   = 3,
    parameter int DW  = 8,
    parameter int AW  = 20,
    parameter int LAT = 9,
    localparam int IW = $clog2(N),
    localparam int KW = $clog2(P)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          ld_is_b,
    input  logic [IW-1:0] ld_idx,
    input  logic [KW-1:0] ld_k,
    input  logic [DW-1:0] ld_data,
    input  logic          start,
    output logic          done,
    input  logic [IW-1:0] rd_row,
    input  logic [IW-1:0] rd_col,
    output logic [AW-1:0] rd_data
);
    logic                 issue, first, last, busy;
    logic [IW-1:0]        slot;
    logic                 ld_ok;
    logic signed [DW-1:0] b_ring [N];
    logic [N-1:0]         wr_vec;
    logic [N-1:0][AW-1:0] c_rows [N];
    logic                 wr_any;

    assign ld_ok  = ld_en && !busy && (int'(ld_idx) < N);
    assign wr_any = |wr_vec;

    ring_matmul_ctrl #(.N(N), .P(P), .LAT(LAT), .IW(IW), .KW(KW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .issue (issue),
        .first (first),
        .last  (last),
        .slot  (slot),
        .busy  (busy),
        .done  (done)
    );

    for (genvar g = 0; g < N; g++) begin : g_pe
        ring_matmul_pe #(
            .N(N), .P(P), .DW(DW), .AW(AW), .LAT(LAT), .IW(IW), .KW(KW)
        ) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_a_we (ld_ok && !ld_is_b && (int'(ld_idx) == g)),
            .ld_b_we (ld_ok &&  ld_is_b && (int'(ld_idx) == g)),
            .ld_k    (ld_k),
            .ld_data (ld_data),
            .issue   (issue),
            .first   (first),
            .last    (last),
            .slot    (slot),
            .b_in    (b_ring[(g + 1) % N]),
            .b_out   (b_ring[g]),
            .wr_en_o (wr_vec[g]),
            .c_row   (c_rows[g])
        );
    end

    // Read port: undo the per-row diagonal rotation.
    always_comb begin
        rd_data = '0;
        if (int'(rd_row) < N && int'(rd_col) < N)
            rd_data = c_rows[rd_row][IW'(ring_slot(int'(rd_col), int'(rd_row), N))];
    end

endmodule

// File: rtl/ring_matmul_chk.sv
// Property checker for ring_matmul, attached by the bind at the end.
// It watches done, start, the read port and the result-write activity.
module ring_matmul_chk #(
    parameter int IW = 2,
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          wr_any,
    input logic [IW-1:0] rd_row,
    input logic [IW-1:0] rd_col,
    input logic [AW-1:0] rd_data
);
    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    a_r10_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |-> !done);

    a_r3_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!($stable(rd_row) && $stable(rd_col)) || $stable(rd_data)));

endmodule

bind ring_matmul ring_matmul_chk #(.IW(IW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .wr_any  (wr_any),
    .rd_row  (rd_row),
    .rd_col  (rd_col),
    .rd_data (rd_data)
);

// File: tb/ring_matmul_tb.sv
// Self-checking bench: a countdown model of done compared every cycle,
// and a triple-loop product compared entry by entry.
module ring_matmul_tb;
    localparam int N   = 4;
    localparam int P   = 3;
    localparam int DW  = 8;
    localparam int AW  = 20;
    localparam int LAT = 9;
    localparam int IW  = $clog2(N);
    localparam int KW  = $clog2(P);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0, ld_is_b = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [KW-1:0] ld_k = '0;
    logic [DW-1:0] ld_data = '0;
    logic          start = 1'b0;
    logic          done;
    logic [IW-1:0] rd_row = '0, rd_col = '0;
    logic [AW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    int ma [N][P];
    int mb [P][N];
    int rem = 0;
    bit mdone = 1'b0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    ring_matmul #(.N(N), .P(P), .DW(DW), .AW(AW), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_is_b(ld_is_b),
        .ld_idx(ld_idx), .ld_k(ld_k), .ld_data(ld_data), .start(start),
        .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference for done (R4, R5, R6): busy for N*P+LAT edges after an accepted start.
    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; mdone = 1'b0;
        end else if (rem > 0) begin
            rem = rem - 1;
            if (rem == 0) mdone = 1'b1;
        end else if (start) begin
            rem = N * P + LAT; mdone = 1'b0;
        end
    end

    // Per-cycle comparison of done against the model.
    always @(negedge clk) begin
        if (model_on) check("R4 R5 R6 done per cycle", int'(done), int'(mdone));
    end

    task automatic load_word(bit is_b, int idx, int k, int val);
        @(negedge clk);
        ld_en = 1'b1; ld_is_b = is_b; ld_idx = IW'(idx); ld_k = KW'(k); ld_data = DW'(val);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // R9: A[i][k] goes with idx=i; B[k][j] goes with idx=j.
    task automatic load_all();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < P; k++) load_word(1'b0, i, k, ma[i][k]);
        for (int j = 0; j < N; j++)
            for (int k = 0; k < P; k++) load_word(1'b1, j, k, mb[k][j]);
    endtask

    // Start, optionally inject a start or a load mid-run, and time done (R4).
    task automatic run(int inj_start_at, int inj_load_at);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 2000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            start = (cnt == inj_start_at);
            if (cnt == inj_load_at) begin
                ld_en = 1'b1; ld_is_b = 1'b0; ld_idx = '0; ld_k = '0; ld_data = DW'(99);
            end else begin
                ld_en = 1'b0;
            end
        end
        start = 1'b0; ld_en = 1'b0;
        check("R4 edges from start to done", cnt, N * P + LAT);
    endtask

    function automatic int ref_c(int r, int c);
        int s = 0;
        for (int k = 0; k < P; k++) s += ma[r][k] * mb[k][c];
        return s;
    endfunction

    task automatic compare_c(string tag);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                @(negedge clk);
                rd_row = IW'(r); rd_col = IW'(c);
                #1;
                check(tag, int'($signed(rd_data)), ref_c(r, c));
            end
    endtask

    task automatic fill_random();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < P; k++) ma[i][k] = int'($urandom_range(0, 255)) - 128;
        for (int k = 0; k < P; k++)
            for (int j = 0; j < N; j++) mb[k][j] = int'($urandom_range(0, 255)) - 128;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state.
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;
        check("R1 done after reset", int'(done), 0);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < P; k++) ma[i][k] = 0;
        for (int k = 0; k < P; k++)
            for (int j = 0; j < N; j++) mb[k][j] = 0;
        compare_c("R1 C after reset");

        // Random matrices (R2, R3, R9).
        for (int t = 0; t < 3; t++) begin
            fill_random();
            load_all();
            run(-1, -1);
            compare_c("R2 R3 R9 random C");
        end

        // Extreme negative operands: signed products and sign extension (R2).
        for (int i = 0; i < N; i++)
            for (int k = 0; k < P; k++) ma[i][k] = -128;
        for (int k = 0; k < P; k++)
            for (int j = 0; j < N; j++) mb[k][j] = (j % 2 == 0) ? -128 : 127;
        load_all();
        run(-1, -1);
        compare_c("R2 extreme C");

        // Identity-like B: each column picks one A entry (R2 R3 ordering).
        fill_random();
        for (int k = 0; k < P; k++)
            for (int j = 0; j < N; j++) mb[k][j] = (j % P == k) ? 1 : 0;
        load_all();
        run(-1, -1);
        compare_c("R2 R3 selector C");

        // R6: start mid-run ignored; R7: load mid-run ignored.
        fill_random();
        load_all();
        run(10, 5);
        compare_c("R6 R7 C after mid-run start and load");

        // R8: restart without reloading gives the same C.
        run(-1, -1);
        compare_c("R8 C after rerun");

        // R10 and R5: C and done unchanged while idling with done high.
        repeat (20) @(negedge clk);
        check("R5 done held", int'(done), 1);
        compare_c("R10 C held after done");

        model_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule